// File: doc/BRIEF.md
# SDRAM Power-Up and Refresh Sequencer

This block sits on the controller side of a single-data-rate SDRAM interface. After reset it drives the memory command pins through the start-up sequence. First it holds the pins at no-operation with clock enable and the data masks high. It then closes both banks with a precharge-all and runs a programmable number of auto-refresh cycles. Finally it loads the mode register from the `mode_key` input. When that sequence completes it raises `init_done`. The mode-register write may come before or after the start-up refreshes, chosen by a parameter.

From then on an interval counter marks each refresh period and keeps a saturating count of refreshes owed. While anything is owed, `ref_req` is high. The host arbiter answers with `ref_gnt`. Grant rules: the sequencer samples `ref_gnt` only while it is idle with a refresh owed and `ref_req` already visible. On the first such cycle it takes the command bus. While it holds the bus `ref_req` stays high, and the host must issue no command until `ref_req` is seen low. The host may keep `ref_gnt` high to let several owed refreshes run back to back.

For each owed refresh the sequencer issues a precharge-all and then an auto-refresh. Every timing gap is a cycle count parameter, with defaults for a 166 MHz clock. The bank address is always driven to zero by this block.

Top module: `sdr_init_refresh`

## Requirements
- R1: While reset is held and until the power-up hold has ended, the pins carry no-operation (CS#,RAS#,CAS#,WE# = 0,1,1,1), clock enable is high, every DQM bit is high, and `init_done` and `ref_req` are low. The first command appears no earlier than `T_HOLD` cycles after reset is released.
- R2: The first command after the hold is precharge-all (0,0,1,0) with address bit `AP_BIT` high and all other address bits zero.
- R3: The next command after any precharge-all appears exactly `T_RP` cycles after it.
- R4: Start-up issues exactly `INIT_REFS` auto-refresh commands (0,0,0,1) with address zero. Consecutive start-up refreshes, and the command that follows the last one, are spaced exactly `T_RC` cycles apart. No command ever follows a refresh by fewer than `T_RC` cycles.
- R5: The mode-register write (0,0,0,0) carries `mode_key` on the address pins. With `MRS_FIRST`=0 it follows the refreshes, and `init_done` rises exactly `T_MRD` cycles after it.
- R6: With `MRS_FIRST`=1 the order is precharge-all, mode-register write, then the refreshes. The first refresh comes exactly `T_MRD` cycles after the mode write, and `init_done` rises exactly `T_RC` cycles after the last refresh.
- R7: Once high, `init_done` stays high, all DQM bits go low, and no mode-register write is issued again.
- R8: `ref_req` first rises exactly `REF_INTERVAL`+1 cycles after `init_done` rises. The interval counter then marks a new owed refresh every `REF_INTERVAL` cycles, whether or not the earlier ones have been served.
- R9: Without `ref_gnt`, an owed refresh has no effect on the pins: no command is issued and `ref_req` stays high.
- R10: A granted refresh is a precharge-all with address bit `AP_BIT` high, followed `T_RP` cycles later by an auto-refresh. If nothing more is owed, `ref_req` falls exactly `T_RC` cycles after that refresh.
- R11: The owed count saturates at `MAX_PENDING`. Under a held grant, exactly that many precharge/refresh pairs run before `ref_req` falls, each precharge at least `T_RC` cycles after the previous refresh.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, all activity on the rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode_key | input | ADDR_W | Value placed on the address pins by the mode-register write |
| ref_gnt | input | 1 | Host grant of the command bus for refresh |
| sd_cke | output | 1 | SDRAM clock enable, held high |
| sd_cs_n | output | 1 | Chip select, active low |
| sd_ras_n | output | 1 | Row strobe, active low |
| sd_cas_n | output | 1 | Column strobe, active low |
| sd_we_n | output | 1 | Write enable, active low |
| sd_addr | output | ADDR_W | SDRAM address pins |
| sd_ba | output | BA_W | Bank address, driven zero |
| sd_dqm | output | DQM_W | Data masks, high until start-up completes |
| init_done | output | 1 | Start-up sequence complete |
| ref_req | output | 1 | Refresh owed or in progress |

## Verification
The bound checker watches the pins on every cycle. It checks the minimum precharge and row-cycle gaps against any following command, the address on precharge, refresh and mode writes, and that `init_done` never drops. It also checks that no mode write follows start-up and that every refresh after start-up happens under a raised `ref_req`. Only the bench scenarios can show the exact gap lengths. They also show the full start-up order in both variants, the request latency and period, the absence of commands without a grant, and that the saturated owed count turns into exactly that many refresh pairs.

// File: rtl/sdr_seq_pkg.sv
package sdr_seq_pkg;

  // Pin order {cs_n, ras_n, cas_n, we_n}
  typedef enum logic [3:0] {
    CMD_MRS = 4'b0000,
    CMD_REF = 4'b0001,
    CMD_PRE = 4'b0010,
    CMD_NOP = 4'b0111
  } sdr_cmd_e;

  typedef enum logic [3:0] {
    ST_HOLD,
    ST_PALL,
    ST_PWAIT,
    ST_IREF,
    ST_IWAIT,
    ST_MRS,
    ST_MWAIT,
    ST_IDLE,
    ST_RPRE,
    ST_RPWAIT,
    ST_RREF,
    ST_RRWAIT
  } seq_state_e;

endpackage

// File: rtl/sdr_gap_timer.sv
module sdr_gap_timer #(
  parameter int CNT_W   = 16,
  parameter int RST_VAL = 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  output logic             expired
);

  localparam logic [CNT_W-1:0] RST_C = CNT_W'(RST_VAL);

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)           cnt_q <= RST_C;
    else if (load)        cnt_q <= load_val;
    else if (cnt_q != '0) cnt_q <= cnt_q - 1'b1;
  end

  assign expired = (cnt_q == '0);

endmodule

// File: rtl/sdr_ref_interval.sv
module sdr_ref_interval #(
  parameter int INTERVAL    = 2589,
  parameter int MAX_PENDING = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic en,
  input  logic take,
  output logic owed
);

  localparam int IV_W = (INTERVAL > 1) ? $clog2(INTERVAL) : 1;
  localparam int PD_W = $clog2(MAX_PENDING + 1);
  localparam logic [IV_W-1:0] IV_LAST = IV_W'(INTERVAL - 1);
  localparam logic [PD_W-1:0] PD_MAX  = PD_W'(MAX_PENDING);

  logic [IV_W-1:0] iv_q;
  logic [PD_W-1:0] pend_q;
  logic            tick;

  assign tick = en && (iv_q == IV_LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    iv_q <= '0;
    else if (!en)  iv_q <= '0;
    else if (tick) iv_q <= '0;
    else           iv_q <= iv_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q <= '0;
    end else begin
      unique case ({tick, take})
        2'b10:   if (pend_q != PD_MAX) pend_q <= pend_q + 1'b1;
        2'b01:   pend_q <= pend_q - 1'b1;
        default: pend_q <= pend_q;
      endcase
    end
  end

  assign owed = (pend_q != '0);

endmodule

// File: rtl/sdr_seq_fsm.sv
module sdr_seq_fsm
  import sdr_seq_pkg::*;
#(
  parameter int T_RP      = 3,
  parameter int T_RC      = 9,
  parameter int T_MRD     = 2,
  parameter int INIT_REFS = 2,
  parameter bit MRS_FIRST = 1'b0,
  parameter int CNT_W     = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             expired,
  input  logic             owed,
  input  logic             ref_gnt,
  input  logic             req_seen,
  output sdr_cmd_e         cmd,
  output logic             load,
  output logic [CNT_W-1:0] load_val,
  output logic             take,
  output logic             at_idle,
  output logic             busy_ref
);

  localparam int IR_W = $clog2(INIT_REFS + 1);
  localparam logic [IR_W-1:0]  IREFS_C = IR_W'(INIT_REFS);
  localparam logic [CNT_W-1:0] LD_RP   = CNT_W'(T_RP - 2);
  localparam logic [CNT_W-1:0] LD_RC   = CNT_W'(T_RC - 2);
  localparam logic [CNT_W-1:0] LD_MRD  = CNT_W'(T_MRD - 2);

  seq_state_e      state_q, nxt;
  logic [IR_W-1:0] irefs_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_HOLD;
      irefs_q <= '0;
    end else begin
      state_q <= nxt;
      if (state_q == ST_IREF) irefs_q <= irefs_q + 1'b1;
    end
  end

  always_comb begin
    nxt      = state_q;
    cmd      = CMD_NOP;
    load     = 1'b0;
    load_val = '0;
    take     = 1'b0;
    unique case (state_q)
      ST_HOLD:  if (expired) nxt = ST_PALL;
      ST_PALL: begin
        cmd = CMD_PRE; load = 1'b1; load_val = LD_RP; nxt = ST_PWAIT;
      end
      ST_PWAIT: if (expired) nxt = MRS_FIRST ? ST_MRS : ST_IREF;
      ST_IREF: begin
        cmd = CMD_REF; load = 1'b1; load_val = LD_RC; nxt = ST_IWAIT;
      end
      ST_IWAIT: begin
        if (expired) begin
          if (irefs_q == IREFS_C) nxt = MRS_FIRST ? ST_IDLE : ST_MRS;
          else                    nxt = ST_IREF;
        end
      end
      ST_MRS: begin
        cmd = CMD_MRS; load = 1'b1; load_val = LD_MRD; nxt = ST_MWAIT;
      end
      ST_MWAIT: if (expired) nxt = MRS_FIRST ? ST_IREF : ST_IDLE;
      ST_IDLE: begin
        if (owed && ref_gnt && req_seen) begin
          take = 1'b1;
          nxt  = ST_RPRE;
        end
      end
      ST_RPRE: begin
        cmd = CMD_PRE; load = 1'b1; load_val = LD_RP; nxt = ST_RPWAIT;
      end
      ST_RPWAIT: if (expired) nxt = ST_RREF;
      ST_RREF: begin
        cmd = CMD_REF; load = 1'b1; load_val = LD_RC; nxt = ST_RRWAIT;
      end
      ST_RRWAIT: if (expired) nxt = ST_IDLE;
      default:   nxt = ST_HOLD;
    endcase
  end

  assign at_idle  = (state_q == ST_IDLE);
  assign busy_ref = (state_q == ST_RPRE) || (state_q == ST_RPWAIT) ||
                    (state_q == ST_RREF) || (state_q == ST_RRWAIT);

endmodule

// File: rtl/sdr_cmd_drive.sv
module sdr_cmd_drive
  import sdr_seq_pkg::*;
#(
  parameter int ADDR_W = 11,
  parameter int DQM_W  = 2,
  parameter int AP_BIT = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  sdr_cmd_e          cmd,
  input  logic [ADDR_W-1:0] mode_key,
  input  logic              ready,
  input  logic              req_now,
  output logic [3:0]        pins,
  output logic [ADDR_W-1:0] addr,
  output logic [DQM_W-1:0]  dqm,
  output logic              done,
  output logic              req
);

  localparam logic [ADDR_W-1:0] AP_MASK = ADDR_W'(1) << AP_BIT;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pins <= CMD_NOP;
      addr <= '0;
      dqm  <= '1;
      done <= 1'b0;
      req  <= 1'b0;
    end else begin
      pins <= cmd;
      unique case (cmd)
        CMD_MRS: addr <= mode_key;
        CMD_PRE: addr <= AP_MASK;
        default: addr <= '0;
      endcase
      dqm  <= {DQM_W{~ready}};
      done <= ready;
      req  <= req_now;
    end
  end

endmodule

// File: rtl/sdr_init_refresh.sv
module sdr_init_refresh
  import sdr_seq_pkg::*;
#(
  parameter int T_HOLD       = 33200,
  parameter int T_RP         = 3,
  parameter int T_RC         = 9,
  parameter int T_MRD        = 2,
  parameter int INIT_REFS    = 2,
  parameter bit MRS_FIRST    = 1'b0,
  parameter int REF_INTERVAL = 2589,
  parameter int MAX_PENDING  = 8,
  parameter int ADDR_W       = 11,
  parameter int BA_W         = 1,
  parameter int DQM_W        = 2,
  parameter int AP_BIT       = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] mode_key,
  input  logic              ref_gnt,
  output logic              sd_cke,
  output logic              sd_cs_n,
  output logic              sd_ras_n,
  output logic              sd_cas_n,
  output logic              sd_we_n,
  output logic [ADDR_W-1:0] sd_addr,
  output logic [BA_W-1:0]   sd_ba,
  output logic [DQM_W-1:0]  sd_dqm,
  output logic              init_done,
  output logic              ref_req
);

  localparam int GAP_MAX = (T_RC > T_RP) ? ((T_RC > T_MRD) ? T_RC : T_MRD)
                                         : ((T_RP > T_MRD) ? T_RP : T_MRD);
  localparam int CNT_MAX = (T_HOLD > GAP_MAX) ? T_HOLD : GAP_MAX;
  localparam int CNT_W   = $clog2(CNT_MAX + 1);

  sdr_cmd_e         cmd;
  logic             load, expired, take, owed;
  logic [CNT_W-1:0] load_val;
  logic             at_idle, busy_ref, ready, req_now;
  logic [3:0]       pins;

  sdr_gap_timer #(
    .CNT_W  (CNT_W),
    .RST_VAL(T_HOLD - 1)
  ) u_timer (
    .clk     (clk),
    .rst_n   (rst_n),
    .load    (load),
    .load_val(load_val),
    .expired (expired)
  );

  sdr_seq_fsm #(
    .T_RP     (T_RP),
    .T_RC     (T_RC),
    .T_MRD    (T_MRD),
    .INIT_REFS(INIT_REFS),
    .MRS_FIRST(MRS_FIRST),
    .CNT_W    (CNT_W)
  ) u_fsm (
    .clk     (clk),
    .rst_n   (rst_n),
    .expired (expired),
    .owed    (owed),
    .ref_gnt (ref_gnt),
    .req_seen(ref_req),
    .cmd     (cmd),
    .load    (load),
    .load_val(load_val),
    .take    (take),
    .at_idle (at_idle),
    .busy_ref(busy_ref)
  );

  sdr_ref_interval #(
    .INTERVAL   (REF_INTERVAL),
    .MAX_PENDING(MAX_PENDING)
  ) u_interval (
    .clk  (clk),
    .rst_n(rst_n),
    .en   (init_done),
    .take (take),
    .owed (owed)
  );

  assign ready   = at_idle | busy_ref;
  assign req_now = busy_ref | (at_idle & owed);

  sdr_cmd_drive #(
    .ADDR_W(ADDR_W),
    .DQM_W (DQM_W),
    .AP_BIT(AP_BIT)
  ) u_drive (
    .clk     (clk),
    .rst_n   (rst_n),
    .cmd     (cmd),
    .mode_key(mode_key),
    .ready   (ready),
    .req_now (req_now),
    .pins    (pins),
    .addr    (sd_addr),
    .dqm     (sd_dqm),
    .done    (init_done),
    .req     (ref_req)
  );

  assign {sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n} = pins;
  assign sd_cke = 1'b1;
  assign sd_ba  = '0;

endmodule

// File: rtl/sdr_init_refresh_chk.sv
module sdr_init_refresh_chk #(
  parameter int T_RP   = 3,
  parameter int T_RC   = 9,
  parameter int T_MRD  = 2,
  parameter int ADDR_W = 11,
  parameter int DQM_W  = 2,
  parameter int AP_BIT = 10
) (
  input logic              clk,
  input logic              rst_n,
  input logic [ADDR_W-1:0] mode_key,
  input logic              sd_cs_n,
  input logic              sd_ras_n,
  input logic              sd_cas_n,
  input logic              sd_we_n,
  input logic [ADDR_W-1:0] sd_addr,
  input logic [DQM_W-1:0]  sd_dqm,
  input logic              init_done,
  input logic              ref_req
);

  localparam int CAP = (T_RC > T_RP) ? ((T_RC > T_MRD) ? T_RC : T_MRD)
                                     : ((T_RP > T_MRD) ? T_RP : T_MRD);
  localparam int CW  = $clog2(CAP + 1);
  localparam logic [CW-1:0] CAP_C = CW'(CAP);
  localparam logic [CW-1:0] RP_C  = CW'(T_RP);
  localparam logic [CW-1:0] RC_C  = CW'(T_RC);
  localparam logic [CW-1:0] MRD_C = CW'(T_MRD);

  logic [3:0]    c;
  logic          is_cmd, is_pre, is_ref, is_mrs;
  logic [CW-1:0] since_pre, since_ref, since_mrs;

  assign c      = {sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n};
  assign is_cmd = (c != 4'b0111);
  assign is_pre = (c == 4'b0010);
  assign is_ref = (c == 4'b0001);
  assign is_mrs = (c == 4'b0000);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      since_pre <= CAP_C;
      since_ref <= CAP_C;
      since_mrs <= CAP_C;
    end else begin
      if (is_pre) since_pre <= CW'(1);
      else if (since_pre != CAP_C) since_pre <= since_pre + 1'b1;
      if (is_ref) since_ref <= CW'(1);
      else if (since_ref != CAP_C) since_ref <= since_ref + 1'b1;
      if (is_mrs) since_mrs <= CW'(1);
      else if (since_mrs != CAP_C) since_mrs <= since_mrs + 1'b1;
    end
  end

  // R1
  mask_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !init_done |-> (sd_dqm == '1));

  // R2
  pre_ap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    is_pre |-> (sd_addr == (ADDR_W'(1) << AP_BIT)));

  // R3
  trp_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    is_cmd |-> (since_pre >= RP_C));

  // R4
  trc_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    is_cmd |-> (since_ref >= RC_C));

  // R4
  ref_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    is_ref |-> (sd_addr == '0));

  // R5
  mrs_key_chk: assert property (@(posedge clk) disable iff (!rst_n)
    is_mrs |-> (sd_addr == $past(mode_key)));

  // R5
  tmrd_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (is_cmd || $rose(init_done)) |-> (since_mrs >= MRD_C));

  // R7
  done_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    init_done |=> init_done);

  // R7
  no_late_mrs_chk: assert property (@(posedge clk) disable iff (!rst_n)
    init_done |-> !is_mrs);

  // R10
  ref_under_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (init_done && is_ref) |-> ref_req);

endmodule

bind sdr_init_refresh sdr_init_refresh_chk #(
  .T_RP  (T_RP),
  .T_RC  (T_RC),
  .T_MRD (T_MRD),
  .ADDR_W(ADDR_W),
  .DQM_W (DQM_W),
  .AP_BIT(AP_BIT)
) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .mode_key (mode_key),
  .sd_cs_n  (sd_cs_n),
  .sd_ras_n (sd_ras_n),
  .sd_cas_n (sd_cas_n),
  .sd_we_n  (sd_we_n),
  .sd_addr  (sd_addr),
  .sd_dqm   (sd_dqm),
  .init_done(init_done),
  .ref_req  (ref_req)
);

// File: tb/sdr_init_refresh_tb.sv
`timescale 1ns/1ps
module sdr_init_refresh_tb;

  localparam int TH = 40;
  localparam int RP = 3;
  localparam int RC = 9;
  localparam int MRD = 2;
  localparam int IV = 60;
  localparam int MP = 3;
  localparam logic [10:0] KEY = 11'h032;
  localparam logic [10:0] APM = 11'h400;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ref_gnt = 1'b0;
  logic [10:0] mode_key = KEY;

  logic cke, cs, ras, cas, we, done, req;
  logic [10:0] addr;
  logic [0:0] ba;
  logic [1:0] dqm;
  logic cke2, cs2, ras2, cas2, we2, done2, req2;
  logic [10:0] addr2;
  logic [0:0] ba2;
  logic [1:0] dqm2;

  always #2 clk = ~clk;

  sdr_init_refresh #(.T_HOLD(TH), .T_RP(RP), .T_RC(RC), .T_MRD(MRD),
    .INIT_REFS(2), .MRS_FIRST(1'b0), .REF_INTERVAL(IV), .MAX_PENDING(MP)) u_dut (
    .clk(clk), .rst_n(rst_n), .mode_key(mode_key), .ref_gnt(ref_gnt),
    .sd_cke(cke), .sd_cs_n(cs), .sd_ras_n(ras), .sd_cas_n(cas), .sd_we_n(we),
    .sd_addr(addr), .sd_ba(ba), .sd_dqm(dqm), .init_done(done), .ref_req(req));

  sdr_init_refresh #(.T_HOLD(TH), .T_RP(RP), .T_RC(RC), .T_MRD(MRD),
    .INIT_REFS(3), .MRS_FIRST(1'b1), .REF_INTERVAL(IV), .MAX_PENDING(MP)) u_dut2 (
    .clk(clk), .rst_n(rst_n), .mode_key(mode_key), .ref_gnt(1'b0),
    .sd_cke(cke2), .sd_cs_n(cs2), .sd_ras_n(ras2), .sd_cas_n(cas2), .sd_we_n(we2),
    .sd_addr(addr2), .sd_ba(ba2), .sd_dqm(dqm2), .init_done(done2), .ref_req(req2));

  int n_chk = 0;
  int n_fail = 0;
  bit finished = 0;

  int cyc = 0;
  int nlog = 0, nlog2 = 0;
  int lg_c[64], lg2_c[64];
  logic [3:0] lg_k[64], lg2_k[64];
  logic [10:0] lg_a[64], lg2_a[64];
  int done_cyc = -1, done2_cyc = -1;
  int nrise = 0, nfall = 0;
  int rise_c[8], fall_c[8];
  logic req_prev = 1'b0;

  always @(negedge clk) begin
    cyc = cyc + 1;
    if ({cs, ras, cas, we} != 4'b0111 && nlog < 64) begin
      lg_c[nlog] = cyc; lg_k[nlog] = {cs, ras, cas, we}; lg_a[nlog] = addr;
      nlog = nlog + 1;
    end
    if ({cs2, ras2, cas2, we2} != 4'b0111 && nlog2 < 64) begin
      lg2_c[nlog2] = cyc; lg2_k[nlog2] = {cs2, ras2, cas2, we2}; lg2_a[nlog2] = addr2;
      nlog2 = nlog2 + 1;
    end
    if (done && done_cyc < 0) done_cyc = cyc;
    if (done2 && done2_cyc < 0) done2_cyc = cyc;
    if (req && !req_prev && nrise < 8) begin rise_c[nrise] = cyc; nrise = nrise + 1; end
    if (!req && req_prev && nfall < 8) begin fall_c[nfall] = cyc; nfall = nfall + 1; end
    req_prev = req;
  end

  task automatic chk(input bit ok, input string rq, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", rq, act, exp);
    end
  endtask

  int rel_cyc;

  task automatic t_reset();
    repeat (4) @(negedge clk);
    #1;
    chk({cs, ras, cas, we} == 4'b0111, "R1 nop in reset", int'({cs, ras, cas, we}), 7);
    chk(cke == 1'b1, "R1 cke high", int'(cke), 1);
    chk(dqm == 2'b11, "R1 dqm high", int'(dqm), 3);
    chk(done == 1'b0, "R1 init_done low", int'(done), 0);
    chk(req == 1'b0, "R1 ref_req low", int'(req), 0);
    @(negedge clk);
    #1;
    rst_n = 1'b1;
    rel_cyc = cyc;
    repeat (TH / 2) @(negedge clk);
    #1;
    chk(nlog == 0, "R1 no command mid-hold", nlog, 0);
    chk(dqm == 2'b11 && done == 1'b0, "R1 dqm/done mid-hold", int'({dqm, done}), 6);
  endtask

  task automatic t_init();
    wait (done_cyc >= 0 && done2_cyc >= 0);
    @(negedge clk);
    #1;
    chk(nlog == 4, "R4 startup command count", nlog, 4);
    chk(lg_k[0] == 4'b0010, "R2 first is precharge-all", int'(lg_k[0]), 2);
    chk(lg_a[0] == APM, "R2 precharge address", int'(lg_a[0]), int'(APM));
    chk(lg_c[0] - rel_cyc >= TH, "R1 hold length", lg_c[0] - rel_cyc, TH);
    chk(lg_k[1] == 4'b0001 && lg_k[2] == 4'b0001, "R4 two refreshes", int'({lg_k[1], lg_k[2]}), 17);
    chk(lg_a[1] == 11'h0 && lg_a[2] == 11'h0, "R4 refresh address zero", int'(lg_a[1] | lg_a[2]), 0);
    chk(lg_c[1] - lg_c[0] == RP, "R3 precharge to refresh", lg_c[1] - lg_c[0], RP);
    chk(lg_c[2] - lg_c[1] == RC, "R4 refresh spacing", lg_c[2] - lg_c[1], RC);
    chk(lg_k[3] == 4'b0000, "R5 mode write code", int'(lg_k[3]), 0);
    chk(lg_a[3] == KEY, "R5 mode key on address", int'(lg_a[3]), int'(KEY));
    chk(lg_c[3] - lg_c[2] == RC, "R4 refresh to mode write", lg_c[3] - lg_c[2], RC);
    chk(done_cyc - lg_c[3] == MRD, "R5 init_done after mode write", done_cyc - lg_c[3], MRD);
    chk(dqm == 2'b00, "R7 dqm released", int'(dqm), 0);
  endtask

  task automatic t_variant();
    chk(nlog2 == 5, "R6 variant command count", nlog2, 5);
    chk(lg2_k[0] == 4'b0010 && lg2_a[0] == APM, "R6 variant precharge-all", int'(lg2_k[0]), 2);
    chk(lg2_k[1] == 4'b0000 && lg2_a[1] == KEY, "R6 variant mode write second", int'(lg2_k[1]), 0);
    chk(lg2_c[1] - lg2_c[0] == RP, "R6 R3 precharge to mode write", lg2_c[1] - lg2_c[0], RP);
    chk(lg2_c[2] - lg2_c[1] == MRD, "R6 mode write to refresh", lg2_c[2] - lg2_c[1], MRD);
    for (int i = 2; i < 5; i++)
      chk(lg2_k[i] == 4'b0001, "R6 variant refresh code", int'(lg2_k[i]), 1);
    chk(lg2_c[3] - lg2_c[2] == RC && lg2_c[4] - lg2_c[3] == RC, "R6 R4 variant refresh spacing",
        lg2_c[4] - lg2_c[3], RC);
    chk(done2_cyc - lg2_c[4] == RC, "R6 init_done after last refresh", done2_cyc - lg2_c[4], RC);
  endtask

  task automatic t_nogrant();
    wait (nrise >= 1);
    #1;
    chk(rise_c[0] - done_cyc == IV + 1, "R8 first request latency", rise_c[0] - done_cyc, IV + 1);
    while (cyc < rise_c[0] + 4 * IV + 4) @(negedge clk);
    #1;
    chk(nlog == 4, "R9 no command without grant", nlog, 4);
    chk(req == 1'b1, "R9 ref_req held", int'(req), 1);
  endtask

  task automatic t_backlog();
    @(negedge clk);
    ref_gnt = 1'b1;
    wait (nfall >= 1);
    @(negedge clk);
    ref_gnt = 1'b0;
    #1;
    chk(nlog == 4 + 2 * MP, "R11 saturated pair count", (nlog - 4) / 2, MP);
    for (int i = 0; i < MP; i++) begin
      int e = 4 + 2 * i;
      chk(lg_k[e] == 4'b0010 && lg_a[e] == APM, "R10 precharge-all with AP", int'(lg_a[e]), int'(APM));
      chk(lg_k[e + 1] == 4'b0001, "R10 refresh follows", int'(lg_k[e + 1]), 1);
      chk(lg_c[e + 1] - lg_c[e] == RP, "R10 precharge to refresh gap", lg_c[e + 1] - lg_c[e], RP);
      if (i > 0)
        chk(lg_c[e] - lg_c[e - 1] >= RC, "R11 refresh to next precharge", lg_c[e] - lg_c[e - 1], RC);
    end
    chk(fall_c[0] - lg_c[3 + 2 * MP] == RC, "R10 ref_req fall after refresh",
        fall_c[0] - lg_c[3 + 2 * MP], RC);
  endtask

  task automatic t_single();
    int base;
    wait (nrise >= 2);
    #1;
    chk(rise_c[1] - rise_c[0] == 5 * IV, "R8 interval keeps running", rise_c[1] - rise_c[0], 5 * IV);
    base = nlog;
    @(negedge clk);
    ref_gnt = 1'b1;
    wait (nfall >= 2);
    @(negedge clk);
    ref_gnt = 1'b0;
    #1;
    chk(nlog == base + 2, "R10 single pair", nlog - base, 2);
    chk(lg_k[base] == 4'b0010 && lg_k[base + 1] == 4'b0001, "R10 single order",
        int'({lg_k[base], lg_k[base + 1]}), 33);
    chk(fall_c[1] - lg_c[base + 1] == RC, "R10 single release", fall_c[1] - lg_c[base + 1], RC);
    for (int i = 4; i < nlog; i++)
      chk(lg_k[i] != 4'b0000, "R7 no mode write after start-up", int'(lg_k[i]), 2);
    chk(done == 1'b1 && dqm == 2'b00, "R7 done held, dqm low", int'({done, dqm}), 4);
  endtask

  initial begin
    t_reset();
    t_init();
    t_variant();
    t_nogrant();
    t_backlog();
    t_single();
    if (!finished) begin
      finished = 1;
      $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      n_chk++;
      n_fail++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
      $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
      $finish;
    end
  end

endmodule